// File: doc/BRIEF.md
# Banked UART Host Register Interface

This block is the processor-facing side of one UART channel. A host reaches it through a 3-bit address, a write strobe and a read strobe. The block keeps the channel's control registers. It also turns the state of the receive FIFO, the transmitter and two external event lines into an interrupt request and an identification code. The serial shifters, the baud generator, the FIFO storage and flow control live outside the block. The block only observes the FIFO count, the FIFO empty flag and a push pulse. It emits a pop pulse when the host reads the receive data and a write pulse when the host loads the transmit data.

The eight addresses are shared by three banks. The value held in the line control register picks the bank. With bit 7 clear, the normal bank is visible. With bit 7 set, the divisor bytes replace the low three addresses. The key value 0xBF instead exposes the extended bank, which holds the feature register and the four flow-control characters. A gate bit in the feature register decides whether the upper bits of the interrupt-enable, FIFO-control and modem-control registers accept writes.

Top module: `uart_hostregs`

## Requirements
- R1: In the normal bank (LCR bit 7 = 0), a write to address 0 raises `thr_wr` for that one cycle and nothing is stored. A read of address 0 returns `rx_data` and raises `rx_pop` for that cycle.
- R2: When LCR bit 7 = 1 and LCR ≠ 0xBF, addresses 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the fractional divisor. No `thr_wr` or `rx_pop` pulse is produced there. Address 3 still holds LCR.
- R3: When LCR = 0xBF, address 2 is the feature register and addresses 4, 5, 6 and 7 are the four flow-control characters. Addresses 0 and 1 remain the divisor bytes. Returning LCR to a value with bit 7 clear restores the normal bank, where address 2 reads ISR.
- R4: When feature register bit 4 is 0, writes leave IER[7:4], FCR[5:4] and MCR[7:5] unchanged while the lower bits take the written value. When bit 4 is 1, all bits are written. FCR is write-only, and its bits 5:4 read back as ISR[5:4].
- R5: IER bit 0 enables the receive-data source, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. A disabled source neither drives `irq` nor appears in ISR.
- R6: With FCR bit 0 = 1 and IER bit 0 = 1, the receive-data source is active while `rx_count` ≥ the trigger level and inactive as soon as the count falls below it. With FCR bit 0 = 0, the source is active while `rx_count` ≥ 1.
- R7: LSR (address 5) bit 0 sets on the cycle after `rx_push`. It clears on the cycle after `rx_empty` is seen without a push, and a push wins over empty. LSR bits 6 and 5 both show `tx_empty`. The other LSR bits read 0.
- R8: FCR[7:6] selects the trigger level: 0 gives DEPTH/8, 1 gives DEPTH/4, 2 gives DEPTH−8 and 3 gives DEPTH−4. For DEPTH = 64 these are 8, 16, 56 and 60.
- R9: ISR[3:0] reports the highest enabled pending source. The order is line status (0x6), then receive data (0x4), then transmit empty (0x2), then modem status (0x0). When nothing is pending it reads 0x1. ISR[7:6] both copy FCR bit 0.
- R10: The transmit-empty source becomes pending on the cycle after a rising edge of `tx_empty`. It is cleared by a transmit write, or by an ISR read while it is the reported source.
- R11: Reset clears LCR, IER, FCR, MCR and the feature register, so ISR reads 0x01.
- R12: `irq` is active-high. It is the combinational OR of the pending enabled sources, so it follows an IER write on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_count | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| rx_push | input | 1 | Pulse: a byte entered the receive FIFO |
| rx_empty | input | 1 | Receive FIFO is empty |
| tx_empty | input | 1 | Transmitter has nothing to send |
| line_evt | input | 1 | Line status condition present |
| modem_evt | input | 1 | Modem status change present |
| thr_wr | output | 1 | Pulse: host wrote transmit data |
| rx_pop | output | 1 | Pulse: host read receive data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is one where several sources are pending at once and the transmit-empty source has to give way. That source only arms on an edge of `tx_empty`, and the ISR read that reports it also removes it. The stimulus arms it with a low-then-high toggle and raises the modem event under it. It then reads ISR twice and expects 0x2 followed by 0x0. Next it stacks a line event over a FIFO count at the trigger level and releases them one at a time. The gate bit is proved by a round trip through the 0xBF bank that turns the gate off. After that, writes to the normal bank must keep the upper bits written while the gate was on.

// File: rtl/uhr_pkg.sv
package uhr_pkg;

  localparam logic [7:0] ENH_KEY = 8'hBF;

  localparam logic [3:0] ISR_LINE  = 4'h6;
  localparam logic [3:0] ISR_RXD   = 4'h4;
  localparam logic [3:0] ISR_THRE  = 4'h2;
  localparam logic [3:0] ISR_MODEM = 4'h0;
  localparam logic [3:0] ISR_NONE  = 4'h1;

  localparam int NUM_XCHAR = 4;

  typedef enum logic [4:0] {
    RID_RXTX, RID_IER, RID_ISRFCR, RID_LCR, RID_MCR, RID_LSR, RID_MSR,
    RID_SPR, RID_DLL, RID_DLM, RID_DLD, RID_EFR,
    RID_XC0, RID_XC1, RID_XC2, RID_XC3
  } reg_id_e;

  typedef struct packed {
    logic line;
    logic rxd;
    logic modem;
  } ext_src_t;

endpackage

// File: rtl/uhr_bank_dec.sv
module uhr_bank_dec
  import uhr_pkg::*;
(
  input  logic [7:0] lcr,
  input  logic [2:0] addr,
  output reg_id_e    rid
);

  logic use_enh;
  logic use_div;

  assign use_enh = (lcr == ENH_KEY);
  assign use_div = lcr[7] & ~use_enh;

  always_comb begin
    unique case (addr)
      3'd0: rid = lcr[7] ? RID_DLL : RID_RXTX;
      3'd1: rid = lcr[7] ? RID_DLM : RID_IER;
      3'd2: rid = use_enh ? RID_EFR : (use_div ? RID_DLD : RID_ISRFCR);
      3'd3: rid = RID_LCR;
      3'd4: rid = use_enh ? RID_XC0 : RID_MCR;
      3'd5: rid = use_enh ? RID_XC1 : RID_LSR;
      3'd6: rid = use_enh ? RID_XC2 : RID_MSR;
      default: rid = use_enh ? RID_XC3 : RID_SPR;
    endcase
  end

endmodule

// File: rtl/uhr_rx_irq.sv
module uhr_rx_irq #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic          rx_empty,
  output logic          rx_ready,
  output logic          data_rdy
);

  localparam logic [CW-1:0] LVL0 = CW'(DEPTH / 8);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH - 8);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH - 4);

  logic [CW-1:0] level;
  logic          dr_d, dr_q;

  always_comb begin
    if (!fifo_en) begin
      level = CW'(1);
    end else begin
      unique case (trig_sel)
        2'd0:    level = LVL0;
        2'd1:    level = LVL1;
        2'd2:    level = LVL2;
        default: level = LVL3;
      endcase
    end
  end

  assign rx_ready = (rx_count >= level);

  always_comb begin
    dr_d = dr_q;
    if (rx_push)       dr_d = 1'b1;
    else if (rx_empty) dr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dr_q <= 1'b0;
    else        dr_q <= dr_d;
  end

  assign data_rdy = dr_q;

  p_dr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> data_rdy);

  p_dr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !rx_push) |=> !data_rdy);

  p_empty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_ready);

endmodule

// File: rtl/uhr_isr.sv
module uhr_isr
  import uhr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ext_src_t  src,
  input  logic [3:0] ien,
  input  logic      tx_empty,
  input  logic      thr_write,
  input  logic      isr_read,
  output logic [3:0] code,
  output logic      irq
);

  logic tx_q, tx_d;
  logic thre_q, thre_d;
  logic tx_rise;
  logic en_rxd, en_thre, en_line, en_modem;

  assign tx_rise = tx_empty & ~tx_q;

  assign en_rxd   = src.rxd   & ien[0];
  assign en_thre  = thre_q    & ien[1];
  assign en_line  = src.line  & ien[2];
  assign en_modem = src.modem & ien[3];

  always_comb begin
    if (en_line)       code = ISR_LINE;
    else if (en_rxd)   code = ISR_RXD;
    else if (en_thre)  code = ISR_THRE;
    else if (en_modem) code = ISR_MODEM;
    else               code = ISR_NONE;
  end

  assign irq = en_line | en_rxd | en_thre | en_modem;

  always_comb begin
    tx_d   = tx_empty;
    thre_d = thre_q;
    if (tx_rise)
      thre_d = 1'b1;
    else if (thr_write || (isr_read && code == ISR_THRE))
      thre_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      thre_q <= thre_d;
    end
  end

  p_thre_rdclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_read && code == ISR_THRE && !tx_rise) |=> (code != ISR_THRE));

  p_thre_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rise && ien[1] && !src.line && !src.rxd) |=> irq);

endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uhr_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    rx_data,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic          rx_empty,
  input  logic          tx_empty,
  input  logic          line_evt,
  input  logic          modem_evt,
  output logic          thr_wr,
  output logic          rx_pop,
  output logic          irq
);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_n_i = rst_s2_q;

  // decode
  reg_id_e rid;
  logic [7:0] lcr_q, lcr_d;

  uhr_bank_dec u_dec (
    .lcr  (lcr_q),
    .addr (addr),
    .rid  (rid)
  );

  // register state
  logic [7:0] ier_q, ier_d;
  logic [7:0] fcr_q, fcr_d;
  logic [7:0] mcr_q, mcr_d;
  logic [7:0] efr_q, efr_d;
  logic [7:0] spr_q, spr_d;
  logic [7:0] dll_q, dll_d;
  logic [7:0] dlm_q, dlm_d;
  logic [7:0] dld_q, dld_d;
  logic [7:0] xc_q [NUM_XCHAR];
  logic [7:0] xc_d [NUM_XCHAR];
  logic       gate_open;

  assign gate_open = efr_q[4];

  always_comb begin
    lcr_d = lcr_q;
    ier_d = ier_q;
    fcr_d = fcr_q;
    mcr_d = mcr_q;
    efr_d = efr_q;
    spr_d = spr_q;
    dll_d = dll_q;
    dlm_d = dlm_q;
    dld_d = dld_q;
    if (wr_en) begin
      unique case (rid)
        RID_IER:    ier_d = gate_open ? wdata : {ier_q[7:4], wdata[3:0]};
        RID_ISRFCR: fcr_d = gate_open ? wdata : {wdata[7:6], fcr_q[5:4], wdata[3:0]};
        RID_LCR:    lcr_d = wdata;
        RID_MCR:    mcr_d = gate_open ? wdata : {mcr_q[7:5], wdata[4:0]};
        RID_SPR:    spr_d = wdata;
        RID_DLL:    dll_d = wdata;
        RID_DLM:    dlm_d = wdata;
        RID_DLD:    dld_d = wdata;
        RID_EFR:    efr_d = wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lcr_q <= '0;
      ier_q <= '0;
      fcr_q <= '0;
      mcr_q <= '0;
      efr_q <= '0;
      spr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      dld_q <= '0;
    end else begin
      lcr_q <= lcr_d;
      ier_q <= ier_d;
      fcr_q <= fcr_d;
      mcr_q <= mcr_d;
      efr_q <= efr_d;
      spr_q <= spr_d;
      dll_q <= dll_d;
      dlm_q <= dlm_d;
      dld_q <= dld_d;
    end
  end

  // flow-control character slots
  for (genvar g = 0; g < NUM_XCHAR; g++) begin : g_xchar
    localparam reg_id_e MY_ID = reg_id_e'(RID_XC0 + g);
    logic wr_hit;
    assign wr_hit = wr_en && (rid == MY_ID);

    always_comb begin
      xc_d[g] = xc_q[g];
      if (wr_hit) xc_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) xc_q[g] <= '0;
      else          xc_q[g] <= xc_d[g];
    end
  end

  // strobes
  logic isr_read;

  assign thr_wr   = wr_en && (rid == RID_RXTX);
  assign rx_pop   = rd_en && (rid == RID_RXTX);
  assign isr_read = rd_en && (rid == RID_ISRFCR);

  // receive level and data-ready
  logic rx_ready, data_rdy;

  uhr_rx_irq #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .fifo_en  (fcr_q[0]),
    .trig_sel (fcr_q[7:6]),
    .rx_count (rx_count),
    .rx_push  (rx_push),
    .rx_empty (rx_empty),
    .rx_ready (rx_ready),
    .data_rdy (data_rdy)
  );

  // interrupt identification
  ext_src_t   src;
  logic [3:0] isr_code;

  assign src.line  = line_evt;
  assign src.rxd   = rx_ready;
  assign src.modem = modem_evt;

  uhr_isr u_isr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .src       (src),
    .ien       (ier_q[3:0]),
    .tx_empty  (tx_empty),
    .thr_write (thr_wr),
    .isr_read  (isr_read),
    .code      (isr_code),
    .irq       (irq)
  );

  // read mux
  always_comb begin
    unique case (rid)
      RID_RXTX:   rdata = rx_data;
      RID_IER:    rdata = ier_q;
      RID_ISRFCR: rdata = {fcr_q[0], fcr_q[0], fcr_q[5:4], isr_code};
      RID_LCR:    rdata = lcr_q;
      RID_MCR:    rdata = mcr_q;
      RID_LSR:    rdata = {1'b0, tx_empty, tx_empty, 4'b0000, data_rdy};
      RID_MSR:    rdata = 8'h00;
      RID_SPR:    rdata = spr_q;
      RID_DLL:    rdata = dll_q;
      RID_DLM:    rdata = dlm_q;
      RID_DLD:    rdata = dld_q;
      RID_EFR:    rdata = efr_q;
      RID_XC0:    rdata = xc_q[0];
      RID_XC1:    rdata = xc_q[1];
      RID_XC2:    rdata = xc_q[2];
      default:    rdata = xc_q[3];
    endcase
  end

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !gate_open |=> ($stable(ier_q[7:4]) && $stable(fcr_q[5:4]) && $stable(mcr_q[7:5])));

  p_thr_std_bank_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (thr_wr || rx_pop) |-> !lcr_q[7]);

  p_code_irq_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (isr_code != ISR_NONE));

  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ier_q[3:0] == 4'h0) |-> !irq);

endmodule

// File: tb/uart_hostregs_tb_top.sv
`timescale 1ns/1ps
module uart_hostregs_tb_top;

  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 44;

  // vector: [19] read, [18:16] addr, [15:8] data or expected, [7:0] requirement number
  localparam logic [19:0] VEC [NV] = '{
    20'hA010B, 20'hB000B, 20'h9000B,              // R11 reset values
    20'h1F104, 20'h90104,                         // R4 gate closed after reset
    20'h38002, 20'h03402, 20'h11202, 20'h25A02,   // R2 divisor bank writes
    20'h83402, 20'h91202, 20'hA5A02, 20'hB8002,   // R2 divisor bank reads
    20'h3BF03, 20'h21003, 20'h41103, 20'h52203,   // R3 extended bank writes
    20'h63303, 20'h74403,
    20'hC1103, 20'hD2203, 20'hE3303, 20'hF4403,   // R3 extended bank reads
    20'hA1003, 20'h83403, 20'h30303, 20'hA0103,
    20'h1F004, 20'h9F004, 20'h4E304, 20'hCE304,   // R4 gate open
    20'h23104, 20'hAF104,
    20'h3BF04, 20'h20004, 20'h30304,              // R4 close gate again
    20'h10504, 20'h9F504, 20'h40104, 20'hCE104,
    20'h20104, 20'hAF104, 20'h10004, 20'h9F004
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    addr;
  logic          wr_en, rd_en;
  logic [7:0]    wdata, rdata, rx_data;
  logic [CW-1:0] rx_count;
  logic          rx_push, rx_empty, tx_empty, line_evt, modem_evt;
  logic          thr_wr, rx_pop, irq;

  int checks = 0;
  int errors = 0;
  int thr_cnt = 0;
  int pop_cnt = 0;

  always #2 clk = ~clk;

  uart_hostregs #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_count(rx_count),
    .rx_push(rx_push), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .line_evt(line_evt), .modem_evt(modem_evt), .thr_wr(thr_wr),
    .rx_pop(rx_pop), .irq(irq)
  );

  always @(posedge clk) begin
    if (thr_wr) thr_cnt <= thr_cnt + 1;
    if (rx_pop) pop_cnt <= pop_cnt + 1;
  end

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string rq);
    logic [7:0] v;
    rd(a, v);
    check(rq, int'(v), int'(exp));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int t0;
    int lv [4] = '{8, 16, 56, 60};
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; rx_data = 8'hA5;
    rx_count = '0; rx_push = 0; rx_empty = 1; tx_empty = 0; line_evt = 0; modem_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], v);
        check($sformatf("R%0d row %0d", VEC[i][7:0], i), int'(v), int'(VEC[i][15:8]));
      end else begin
        wr(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R1: transmit write pulse, receive read pop
    t0 = thr_cnt;
    wr(3'd0, 8'h77);
    check("R1 thr_wr pulses", thr_cnt - t0, 1);
    t0 = pop_cnt;
    rd(3'd0, v);
    check("R1 rhr data", int'(v), 8'hA5);
    check("R1 rx_pop pulses", pop_cnt - t0, 1);

    // R2: no pulses in the divisor bank
    wr(3'd3, 8'h80);
    t0 = thr_cnt;
    wr(3'd0, 8'h34);
    check("R2 no thr_wr in divisor bank", thr_cnt - t0, 0);
    t0 = pop_cnt;
    rd(3'd0, v);
    check("R2 no rx_pop in divisor bank", pop_cnt - t0, 0);
    check("R2 dll readback", int'(v), 8'h34);
    wr(3'd3, 8'h03);

    // R6 / R8: trigger levels, FCR[5:4] kept at 3 by the closed gate
    wr(3'd1, 8'h01);
    rx_empty = 0;
    for (int s = 0; s < 4; s++) begin
      wr(3'd2, {s[1:0], 6'b000001});
      @(negedge clk); rx_count = CW'(lv[s] - 1);
      #1 check($sformatf("R8 below level sel %0d irq", s), int'(irq), 0);
      @(negedge clk); rx_count = CW'(lv[s]);
      #1 check($sformatf("R8 at level sel %0d irq", s), int'(irq), 1);
      rd_chk(3'd2, 8'hF4, "R6 isr code at level");
      @(negedge clk); rx_count = CW'(lv[s] - 1);
      #1 check("R6 drop below clears irq", int'(irq), 0);
      rd_chk(3'd2, 8'hF1, "R6 isr after drop");
    end
    wr(3'd2, 8'h00);
    @(negedge clk); rx_count = CW'(1);
    #1 check("R6 fifo off one byte irq", int'(irq), 1);
    rd_chk(3'd2, 8'h34, "R6 fifo off isr");
    @(negedge clk); rx_count = '0;
    #1 check("R6 fifo off empty irq", int'(irq), 0);
    wr(3'd2, 8'h01);

    // R7: data ready
    @(negedge clk); rx_push = 1; rx_empty = 0;
    @(negedge clk); rx_push = 0;
    rd_chk(3'd5, 8'h01, "R7 lsr dr set");
    @(negedge clk); rx_push = 1; rx_empty = 1;
    @(negedge clk); rx_push = 0;
    rd_chk(3'd5, 8'h00, "R7 lsr dr cleared on empty");

    // R10 / R9 / R5 / R12: transmit-empty and priority
    wr(3'd1, 8'h0F);
    @(negedge clk); tx_empty = 1;
    @(negedge clk);
    #1 check("R10 tx rise raises irq", int'(irq), 1);
    rd_chk(3'd2, 8'hF2, "R10 isr thre");
    #1 check("R10 isr read clears irq", int'(irq), 0);
    rd_chk(3'd2, 8'hF1, "R10 isr none after clear");
    rd_chk(3'd5, 8'h60, "R7 lsr tx bits");
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    @(negedge clk);
    #1 check("R10 re-armed", int'(irq), 1);
    wr(3'd0, 8'h55);
    #1 check("R10 thr write clears", int'(irq), 0);
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1; modem_evt = 1;
    @(negedge clk);
    rd_chk(3'd2, 8'hF2, "R9 thre above modem");
    rd_chk(3'd2, 8'hF0, "R9 modem after thre read");
    @(negedge clk); line_evt = 1; rx_count = CW'(8); rx_empty = 0;
    #1 rd_chk(3'd2, 8'hF6, "R9 line highest");
    @(negedge clk); line_evt = 0;
    rd_chk(3'd2, 8'hF4, "R9 rx above modem");
    @(negedge clk); rx_count = '0; modem_evt = 0;
    rd_chk(3'd2, 8'hF1, "R9 none pending");
    @(negedge clk); line_evt = 1;
    wr(3'd1, 8'h0B);
    #1 check("R5 masked line no irq", int'(irq), 0);
    rd_chk(3'd2, 8'hF1, "R5 masked line not in isr");
    wr(3'd1, 8'h0F);
    #1 check("R12 irq follows ier", int'(irq), 1);
    @(negedge clk); line_evt = 0;
    #1 check("R12 irq combinational drop", int'(irq), 0);

    // R11: reset in mid-run
    @(negedge clk); tx_empty = 0; rst_n = 0;
    #1 check("R11 irq in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    rd_chk(3'd2, 8'h01, "R11 isr after reset");
    rd_chk(3'd1, 8'h00, "R11 ier after reset");
    rd_chk(3'd3, 8'h00, "R11 lcr after reset");
    rd_chk(3'd4, 8'h00, "R11 mcr after reset");

    finish_run();
  end

endmodule